// File: doc/BRIEF.md
# Low-Frequency Oscillator Controller

This block is the digital control wrapper around a 32.768 kHz oscillator. The oscillator itself is analog and out of scope. Its raw waveform arrives on `osc_raw`, a slow signal that the controller synchronises into its own clock domain. A 12-bit configuration word sets the following:

- whether the oscillator is enabled;
- whether it works with a crystal or with an external clock;
- the crystal drive gain;
- which outputs are enabled;
- how it behaves in standby;
- whether it runs only on demand;
- how long its output stays masked after start;
- whether the configuration is locked.

The controller decides from the CPU sleep state and a peripheral request line whether the oscillator runs. It counts raw rising edges during a programmable start-up window, with the output held low. It then raises a ready flag, and the rising edge of that flag posts an interrupt. After ready, the controller gates a 32.768 kHz output and a divided 1.024 kHz output. It also drives the pin-override controls for the crystal input and output pins.

There are two reset inputs. Power-on reset (`por_n`, asynchronous) clears everything. System reset (`sys_rst`, synchronous) has two exceptions. It spares an oscillator that runs unconditionally (enabled with on-demand cleared), and it spares a locked configuration.

Top module: `lfosc_ctrl`

## Requirements
- R1: After power-on reset the configuration reads 0, neither pin is overridden, the oscillator is stopped, and ready, the interrupt and both clock outputs are low.
- R2: When enabled in crystal mode both `pin_ovr_in` and `pin_ovr_out` are 1. When enabled in external-clock mode only `pin_ovr_in` is 1. When disabled both are 0.
- R3: Configuration bit positions are: [0] enable, [1] mode (1 = crystal, 0 = external clock), [2] on-demand, [3] run-in-standby, [4] 32 kHz output enable, [5] 1 kHz output enable, [8:6] start-up code, [10:9] gain, [11] write lock. `gain_out` shows the gain code in crystal mode and 0 in external-clock mode.
- R4: With enable = 0, `osc_run` is 0. With enable = 1 outside standby (`in_standby` = 0), `osc_run` is 1 when on-demand = 0 and equals `periph_req` when on-demand = 1.
- R5: In standby with enable = 1, `osc_run` is 1 when run-in-standby = 1 and on-demand = 0. In every other standby case it equals `periph_req`.
- R6: Once the write-lock bit reads 1, writes and system resets leave the configuration unchanged until power-on reset.
- R7: A system reset with enable = 1 and on-demand = 0 keeps the configuration and a running, ready oscillator. Any other unlocked system reset clears the configuration and ready.
- R8: After the oscillator starts, `osc_ready` stays 0 for the first 2^(n+3) − 1 raw rising edges, where n is the start-up code. It becomes 1 within three clock cycles of edge number 2^(n+3).
- R9: A 0-to-1 change of ready sets a pending interrupt. `irq` shows it while `irq_en` = 1, and `irq_clr` clears it.
- R10: `clk32_out` follows the synchronised raw clock only while ready and the 32 kHz output enable are both 1. Otherwise it is 0.
- R11: `clk1k_out` is the raw clock divided by 32. Its first change comes 16 raw edges after ready, and it is forced to 0 when the 1 kHz enable is 0 or ready is 0.
- R12: Stopping the oscillator clears ready on the next clock, and the next start counts the full start-up window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst | input | 1 | System reset, active high, synchronous |
| osc_raw | input | 1 | Raw oscillator waveform |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 12 | Configuration write value |
| in_standby | input | 1 | CPU is in standby (0 = active or idle) |
| periph_req | input | 1 | A peripheral requests the clock |
| irq_en | input | 1 | Interrupt enable for the ready event |
| irq_clr | input | 1 | Clears the pending ready interrupt |
| cfg_out | output | 12 | Current configuration |
| osc_run | output | 1 | Oscillator run command |
| osc_ready | output | 1 | Start-up window has elapsed |
| irq | output | 1 | Ready interrupt |
| pin_ovr_in | output | 1 | Oscillator input pin taken from GPIO |
| pin_ovr_out | output | 1 | Oscillator output pin taken from GPIO |
| gain_out | output | 2 | Crystal gain code to the analog core |
| clk32_out | output | 1 | Masked 32.768 kHz clock |
| clk1k_out | output | 1 | Masked 1.024 kHz clock |

## Verification
The bench builds the block with the default parameters: a 3-bit start-up code, a 2-bit gain and a divide-by-32 second output. Under these defaults the shortest start-up window is 8 raw edges and the longest is 1024, so every code, including the largest, fits in one run. The raw clock toggles every four system cycles, which puts every raw edge several clock cycles away from the next. Each edge count in a start-up window can therefore be pinned to the exact edge. The run table is swept at random across sleep state, request, on-demand and run-in-standby.

// File: rtl/lfosc_pkg.sv
package lfosc_pkg;

    localparam int GAIN_W = 2;
    localparam int SU_W   = 3;

    typedef struct packed {
        logic              wlock;
        logic [GAIN_W-1:0] gain;
        logic [SU_W-1:0]   startup;
        logic              en1k;
        logic              en32k;
        logic              runstdby;
        logic              ondemand;
        logic              xtal;
        logic              enable;
    } lfosc_cfg_t;

    localparam int CFG_W = $bits(lfosc_cfg_t);

endpackage

// File: rtl/lfosc_run_table.sv
module lfosc_run_table (
    input  logic enable,
    input  logic ondemand,
    input  logic runstdby,
    input  logic standby,
    input  logic req,
    output logic run
);
    logic free_run;

    always_comb begin
        free_run = !ondemand && (!standby || runstdby);
        run      = enable && (free_run || req);
    end
endmodule

// File: rtl/lfosc_startup.sv
module lfosc_startup #(
    parameter int SU_W  = 3,
    parameter int DIV_W = 5
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            clear,
    input  logic            tick,
    input  logic [SU_W-1:0] startup,
    output logic            ready,
    output logic            ready_rise,
    output logic            div_msb
);
    localparam int CNT_W = (1 << SU_W) + 3;
    localparam int SH_W  = SU_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ready;
        logic [DIV_W-1:0] div;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] target;
    logic [SH_W-1:0]  shamt;

    always_comb begin
        shamt  = SH_W'(startup) + SH_W'(3);
        target = CNT_W'(1) << shamt;
        st_d   = st_q;
        if (clear) begin
            st_d = '0;
        end else if (tick) begin
            if (st_q.ready) begin
                st_d.div = st_q.div + DIV_W'(1);
            end else if (st_q.cnt == target - CNT_W'(1)) begin
                st_d.ready = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready      = st_q.ready;
    assign ready_rise = st_d.ready && !st_q.ready;
    assign div_msb    = st_q.div[DIV_W-1];
endmodule

// File: rtl/lfosc_ctrl.sv
module lfosc_ctrl
    import lfosc_pkg::*;
#(
    parameter int DIV_W = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              osc_raw,
    input  logic              wr_en,
    input  logic [CFG_W-1:0]  wr_data,
    input  logic              in_standby,
    input  logic              periph_req,
    input  logic              irq_en,
    input  logic              irq_clr,
    output logic [CFG_W-1:0]  cfg_out,
    output logic              osc_run,
    output logic              osc_ready,
    output logic              irq,
    output logic              pin_ovr_in,
    output logic              pin_ovr_out,
    output logic [GAIN_W-1:0] gain_out,
    output logic              clk32_out,
    output logic              clk1k_out
);
    typedef struct packed {
        lfosc_cfg_t cfg;
        logic       s1;
        logic       s2;
        logic       pend;
    } top_t;

    top_t r_d, r_q;
    logic run, keep, clear, tick, ready, rise, div_msb;

    lfosc_run_table u_table (
        .enable   (r_q.cfg.enable),
        .ondemand (r_q.cfg.ondemand),
        .runstdby (r_q.cfg.runstdby),
        .standby  (in_standby),
        .req      (periph_req),
        .run      (run)
    );

    lfosc_startup #(.SU_W(SU_W), .DIV_W(DIV_W)) u_startup (
        .clk        (clk),
        .por_n      (por_n),
        .clear      (clear),
        .tick       (tick),
        .startup    (r_q.cfg.startup),
        .ready      (ready),
        .ready_rise (rise),
        .div_msb    (div_msb)
    );

    always_comb begin
        keep  = r_q.cfg.enable && !r_q.cfg.ondemand;
        clear = !run || (sys_rst && !keep);
        tick  = r_q.s1 && !r_q.s2;
        r_d    = r_q;
        r_d.s1 = osc_raw;
        r_d.s2 = r_q.s1;
        if (sys_rst) begin
            if (!(keep || r_q.cfg.wlock)) r_d.cfg = '0;
        end else if (wr_en && !r_q.cfg.wlock) begin
            r_d.cfg = lfosc_cfg_t'(wr_data);
        end
        r_d.pend = (r_q.pend && !irq_clr && !sys_rst) || rise;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg_out     = r_q.cfg;
    assign osc_run     = run;
    assign osc_ready   = ready;
    assign irq         = r_q.pend && irq_en;
    assign pin_ovr_in  = r_q.cfg.enable;
    assign pin_ovr_out = r_q.cfg.enable && r_q.cfg.xtal;
    assign gain_out    = r_q.cfg.xtal ? r_q.cfg.gain : '0;
    assign clk32_out   = r_q.s1 && ready && r_q.cfg.en32k;
    assign clk1k_out   = div_msb && ready && r_q.cfg.en1k;
endmodule

// File: rtl/lfosc_ctrl_chk.sv
module lfosc_ctrl_chk
    import lfosc_pkg::*;
(
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst,
    input logic             irq_en,
    input logic [CFG_W-1:0] cfg_out,
    input logic             osc_run,
    input logic             osc_ready,
    input logic             irq,
    input logic             pin_ovr_in,
    input logic             pin_ovr_out,
    input logic             clk32_out,
    input logic             clk1k_out
);
    a_r4_stop_when_disabled: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_out[0] |-> !osc_run);

    a_r2_out_pin_needs_in_pin: assert property (@(posedge clk) disable iff (!por_n)
        pin_ovr_out |-> pin_ovr_in);

    a_r6_locked_cfg_stable: assert property (@(posedge clk) disable iff (!por_n)
        cfg_out[11] |=> $stable(cfg_out));

    a_r7_keep_ready_on_sysrst: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst && cfg_out[0] && !cfg_out[2] && osc_run && osc_ready) |=> osc_ready);

    a_r9_irq_on_ready_rise: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(osc_ready) && irq_en) |-> irq);

    a_r10_mask_32k: assert property (@(posedge clk) disable iff (!por_n)
        !osc_ready |-> !clk32_out);

    a_r11_mask_1k: assert property (@(posedge clk) disable iff (!por_n)
        !osc_ready |-> !clk1k_out);

    a_r12_stop_clears_ready: assert property (@(posedge clk) disable iff (!por_n)
        !osc_run |=> !osc_ready);
endmodule

bind lfosc_ctrl lfosc_ctrl_chk u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst     (sys_rst),
    .irq_en      (irq_en),
    .cfg_out     (cfg_out),
    .osc_run     (osc_run),
    .osc_ready   (osc_ready),
    .irq         (irq),
    .pin_ovr_in  (pin_ovr_in),
    .pin_ovr_out (pin_ovr_out),
    .clk32_out   (clk32_out),
    .clk1k_out   (clk1k_out)
);

// File: tb/lfosc_ctrl_test.sv
module lfosc_ctrl_test;
    logic clk = 0, por_n = 0, sys_rst = 0, osc_raw = 0;
    logic wr_en = 0, in_standby = 0, periph_req = 0, irq_en = 0, irq_clr = 0;
    logic [11:0] wr_data = '0;
    logic [11:0] cfg_out;
    logic osc_run, osc_ready, irq, pin_ovr_in, pin_ovr_out, clk32_out, clk1k_out;
    logic [1:0] gain_out;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    lfosc_ctrl uut (.*);

    always #5 clk = ~clk;
    initial begin #3; forever #40 osc_raw = ~osc_raw; end

    function automatic logic [11:0] mk(bit en, bit xt, bit od, bit rs, bit e32,
                                        bit e1, int su, int gn, bit lk);
        logic [11:0] v = '0;
        v[0] = en; v[1] = xt; v[2] = od; v[3] = rs; v[4] = e32; v[5] = e1;
        v[8:6] = 3'(su); v[10:9] = 2'(gn); v[11] = lk;
        return v;
    endfunction

    function automatic bit exp_run(logic [11:0] c, bit stby, bit req);
        if (!c[0]) return 0;
        if (c[2]) return req;
        if (!stby) return 1;
        return c[3] ? 1'b1 : req;
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", r, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] v);
        @(negedge clk); wr_en = 1; wr_data = v;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge osc_raw);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 0;
        repeat (2) @(negedge clk); por_n = 1;
        @(negedge clk);
    endtask

    task automatic pulse_sysrst();
        @(negedge clk); sys_rst = 1;
        @(negedge clk); sys_rst = 0;
    endtask

    // Starts from a stopped oscillator and checks the start-up window (R8, R12).
    task automatic start_check(logic [11:0] v);
        int tgt = 1 << (int'(v[8:6]) + 3);
        wr(12'h000);
        @(negedge clk);
        chk("R12 ready cleared on stop", osc_ready, 0);
        @(negedge osc_raw);
        wr(v);
        edges(tgt - 1);
        chk("R8 still masked one edge early", osc_ready, 0);
        chk("R10 32k masked during start-up", clk32_out, 0);
        edges(1);
        chk("R8 ready after full window", osc_ready, 1);
    endtask

    initial begin
        logic [11:0] v;
        bit s, q;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg", cfg_out, 0);
        chk("R1 ovr", {pin_ovr_in, pin_ovr_out}, 0);
        chk("R1 run", osc_run, 0);
        chk("R1 ready/irq/clk", {osc_ready, irq, clk32_out, clk1k_out}, 0);

        // Crystal mode, R2/R3, start-up with code 0 and interrupt
        irq_en = 1;
        v = mk(1, 1, 0, 0, 1, 1, 0, 3, 0);
        start_check(v);
        chk("R2 crystal pins", {pin_ovr_in, pin_ovr_out}, 2'b11);
        chk("R3 gain crystal", gain_out, 3);
        chk("R9 irq after ready", irq, 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        chk("R9 irq cleared", irq, 0);
        // R10 32 kHz gating
        @(posedge osc_raw); repeat (2) @(negedge clk);
        chk("R10 32k high phase", clk32_out, 1);
        @(negedge osc_raw); repeat (2) @(negedge clk);
        chk("R10 32k low phase", clk32_out, 0);

        // R11 divider, restart so the divider starts at zero
        start_check(v);
        begin
            int tr = 0;
            bit prev = clk1k_out;
            for (int i = 1; i <= 64; i++) begin
                edges(1);
                if (i == 15) chk("R11 1k low before 16", clk1k_out, 0);
                if (i == 16) chk("R11 1k high at 16", clk1k_out, 1);
                if (clk1k_out != prev) tr++;
                prev = clk1k_out;
            end
            chk("R11 toggles in 64 edges", tr, 4);
        end
        wr(mk(1, 1, 0, 0, 0, 0, 0, 3, 0));
        edges(20);
        chk("R11 1k off when disabled", clk1k_out, 0);
        chk("R10 32k off when disabled", clk32_out, 0);

        // External mode, longer start-up codes, no irq
        irq_en = 0;
        v = mk(1, 0, 0, 0, 1, 0, 1, 2, 0);
        start_check(v);
        chk("R2 external pins", {pin_ovr_in, pin_ovr_out}, 2'b10);
        chk("R3 gain external", gain_out, 0);
        chk("R9 irq masked", irq, 0);
        start_check(mk(1, 1, 0, 0, 0, 0, 2, 1, 0));
        start_check(mk(1, 1, 0, 0, 0, 0, 7, 1, 0));

        // R7 retention across system reset
        v = mk(1, 1, 0, 1, 0, 0, 0, 2, 0);
        start_check(v);
        pulse_sysrst(); @(negedge clk);
        chk("R7 cfg kept", cfg_out, v);
        chk("R7 ready kept", osc_ready, 1);
        periph_req = 1;
        v = mk(1, 1, 1, 0, 0, 0, 0, 2, 0);
        start_check(v);
        pulse_sysrst(); @(negedge clk);
        chk("R7 cfg cleared", cfg_out, 0);
        chk("R7 ready cleared", osc_ready, 0);
        periph_req = 0;

        // R6 lock
        v = mk(1, 1, 1, 0, 1, 0, 3, 1, 1);
        wr(v);
        wr(12'h000);
        chk("R6 write ignored", cfg_out, v);
        pulse_sysrst(); @(negedge clk);
        chk("R6 sysrst ignored", cfg_out, v);
        do_por();
        chk("R6 por clears lock", cfg_out, 0);
        chk("R1 por pins", {pin_ovr_in, pin_ovr_out}, 0);

        // R4/R5 random sweep of the run table
        for (int i = 0; i < 60; i++) begin
            v = 12'($urandom()) & 12'h7ff;
            s = 1'($urandom()); q = 1'($urandom());
            wr(v);
            @(negedge clk); in_standby = s; periph_req = q;
            #1;
            chk(s ? "R5 standby run" : "R4 active run", osc_run, exp_run(v, s, q));
            chk("R2 pins", {pin_ovr_in, pin_ovr_out}, {v[0], v[0] & v[1]});
            chk("R3 gain", gain_out, v[1] ? v[10:9] : 2'b00);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule